// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Front End

This block is the digital side of a two-channel 8-bit converter. A host writes 16-bit command words over a three-wire link: an active-low select, a serial clock and a data line. All three are brought into the system clock domain through a synchroniser. While select is low, each rising edge of the serial clock shifts one bit into a frame register. When select rises, the collected word is acted on, but only if exactly sixteen bits have arrived.

The control byte is not decoded. Each control bit does one job on its own. A load bit copies the data byte into its channel's code register. A shutdown bit sets or clears its channel's shutdown flag. While a channel is shut down, its output code is forced to zero and its enable is low, and the stored code is kept. The stored codes and flags also appear on a parallel readback port for verification.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset both stored codes are 0x00, both shutdown flags are 0, both output enables are 1 and both output codes are 0x00.
- R2: Bits are captured MSB first on serial clock rising edges while select is low. In sending order the sixteen bits are: U1, U2, U3, SB, SA, U4, LB, LA, then D7 down to D0. So the word's bit 12 is SB, bit 11 is SA, bit 9 is LB, bit 8 is LA, and bits 7:0 are the data byte.
- R3: In an executed command, LA=1 writes the data byte into the channel A code and LB=1 writes it into the channel B code. When both are 1, both channels receive the same byte.
- R4: A load bit of 0 leaves that channel's stored code unchanged.
- R5: Every executed command sets channel A's shutdown flag to SA and channel B's flag to SB (1 = shut down, 0 = active). Loads and shutdown changes in the same command both take effect.
- R6: While a channel is shut down, its output code is 0x00 and its enable is 0, and its stored code is kept. While the channel is active, its output code equals the stored code and its enable is 1.
- R7: A command takes effect only after select rises, within 4 system clock cycles. Nothing changes while the frame is still being shifted in.
- R8: If select rises after any bit count other than 16 (for example 15 or 17), no code and no flag changes.
- R9: A frame sent as two 8-bit bursts, with select held low through the pause, executes as one command.
- R10: The uncommitted bits U1 to U4 have no effect on the result.
- R11: Serial clock edges that occur while select is high are not counted toward the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_din | input | 1 | Serial data, MSB first |
| out_code_a | output | 8 | Channel A code driven to the converter (0 while shut down) |
| out_code_b | output | 8 | Channel B code driven to the converter (0 while shut down) |
| out_en_a | output | 1 | Channel A output enable (0 = high impedance) |
| out_en_b | output | 1 | Channel B output enable (0 = high impedance) |
| rb_code_a | output | 8 | Readback of the channel A stored code |
| rb_code_b | output | 8 | Readback of the channel B stored code |
| rb_sd_a | output | 1 | Readback of the channel A shutdown flag |
| rb_sd_b | output | 1 | Readback of the channel B shutdown flag |

## Verification
The assertions check three things on every cycle:
- Stored codes and flags move only in the cycle after an accepted command.
- An accepted command loads codes according to its load bits and copies its shutdown bits into the flags.
- Each output code and enable agrees with its stored code and flag.

Only the bench's scenarios can show the parts that depend on whole serial sequences:
- the bit order on the wire;
- rejection of 15- and 17-bit frames;
- split frames;
- clock edges while select is high;
- uncommitted bits being ignored.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CODE_W     = 8;
  localparam int NUM_CH     = 2;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = {CNT_W{1'b1}};

  typedef struct packed {
    logic              u1;
    logic              u2;
    logic              u3;
    logic              shut_b;
    logic              shut_a;
    logic              u4;
    logic              load_b;
    logic              load_a;
    logic [CODE_W-1:0] data;
  } cmd_word_t;

  function automatic logic [FRAME_BITS-1:0] shift_bit(logic [FRAME_BITS-1:0] sr, logic b);
    return {sr[FRAME_BITS-2:0], b};
  endfunction

  function automatic logic [CNT_W-1:0] count_up(logic [CNT_W-1:0] c);
    return (c == CNT_SAT) ? c : c + 1'b1;
  endfunction

  function automatic logic chan_load(cmd_word_t w, int ch);
    return (ch == 0) ? w.load_a : w.load_b;
  endfunction

  function automatic logic chan_shut(cmd_word_t w, int ch);
    return (ch == 0) ? w.shut_a : w.shut_b;
  endfunction

  function automatic logic [CODE_W-1:0] drive_code(logic [CODE_W-1:0] c, logic shut);
    return shut ? '0 : c;
  endfunction
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dacif_deser.sv
module dacif_deser
  import dacif_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_cs_n,
  input  logic                  s_sclk,
  input  logic                  s_din,
  output logic [FRAME_BITS-1:0] frame_q,
  output logic [CNT_W-1:0]      bit_cnt,
  output logic                  sclk_rise,
  output logic                  cs_rise,
  output logic                  exec,
  output logic                  drop
);
  logic prev_sclk;
  logic prev_cs_n;

  assign sclk_rise = s_sclk & ~prev_sclk & ~s_cs_n;
  assign cs_rise   = s_cs_n & ~prev_cs_n;
  assign exec      = cs_rise & (bit_cnt == CNT_FULL);
  assign drop      = cs_rise & (bit_cnt != CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sclk <= 1'b0;
      prev_cs_n <= 1'b1;
    end else begin
      prev_sclk <= s_sclk;
      prev_cs_n <= s_cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      frame_q <= '0;
    end else begin
      if (s_cs_n) bit_cnt <= '0;
      else if (sclk_rise) bit_cnt <= count_up(bit_cnt);
      if (sclk_rise) frame_q <= shift_bit(frame_q, s_din);
    end
  end
endmodule

// File: rtl/dacif_chan.sv
module dacif_chan
  import dacif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec,
  input  logic              load,
  input  logic              shut_cmd,
  input  logic [CODE_W-1:0] data,
  output logic [CODE_W-1:0] code_q,
  output logic              shut_q,
  output logic [CODE_W-1:0] out_code,
  output logic              out_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      shut_q <= 1'b0;
    end else if (exec) begin
      if (load) code_q <= data;
      shut_q <= shut_cmd;
    end
  end

  assign out_code = drive_code(code_q, shut_q);
  assign out_en   = ~shut_q;
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dacif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_cs_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic [CODE_W-1:0] out_code_a,
  output logic [CODE_W-1:0] out_code_b,
  output logic              out_en_a,
  output logic              out_en_b,
  output logic [CODE_W-1:0] rb_code_a,
  output logic [CODE_W-1:0] rb_code_b,
  output logic              rb_sd_a,
  output logic              rb_sd_b
);
  logic [2:0]            sync_q;
  logic                  s_cs_n, s_sclk, s_din;
  logic [FRAME_BITS-1:0] frame_q;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  evt_sclk_rise, evt_cs_rise, evt_exec, evt_drop;
  cmd_word_t             cmd_word;
  logic                  unused_ubits;

  logic [CODE_W-1:0] ch_code  [NUM_CH];
  logic [CODE_W-1:0] ch_out   [NUM_CH];
  logic              ch_shut  [NUM_CH];
  logic              ch_en    [NUM_CH];

  dacif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_cs_n, ser_clk, ser_din}),
    .q(sync_q)
  );
  assign {s_cs_n, s_sclk, s_din} = sync_q;

  dacif_deser u_deser (
    .clk(clk), .rst_n(rst_n),
    .s_cs_n(s_cs_n), .s_sclk(s_sclk), .s_din(s_din),
    .frame_q(frame_q), .bit_cnt(bit_cnt),
    .sclk_rise(evt_sclk_rise), .cs_rise(evt_cs_rise),
    .exec(evt_exec), .drop(evt_drop)
  );

  assign cmd_word     = cmd_word_t'(frame_q);
  assign unused_ubits = ^{cmd_word.u1, cmd_word.u2, cmd_word.u3, cmd_word.u4,
                          bit_cnt[0], evt_sclk_rise, evt_cs_rise, evt_drop};

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      dacif_chan u_chan (
        .clk(clk), .rst_n(rst_n),
        .exec(evt_exec),
        .load(chan_load(cmd_word, c)),
        .shut_cmd(chan_shut(cmd_word, c)),
        .data(cmd_word.data),
        .code_q(ch_code[c]), .shut_q(ch_shut[c]),
        .out_code(ch_out[c]), .out_en(ch_en[c])
      );
    end
  endgenerate

  assign out_code_a = ch_out[0];
  assign out_code_b = ch_out[1];
  assign out_en_a   = ch_en[0];
  assign out_en_b   = ch_en[1];
  assign rb_code_a  = ch_code[0];
  assign rb_code_b  = ch_code[1];
  assign rb_sd_a    = ch_shut[0];
  assign rb_sd_b    = ch_shut[1];
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_exec,
  input logic [15:0] cmd_word,
  input logic [7:0]  rb_code_a,
  input logic [7:0]  rb_code_b,
  input logic        rb_sd_a,
  input logic        rb_sd_b,
  input logic [7:0]  out_code_a,
  input logic [7:0]  out_code_b,
  input logic        out_en_a,
  input logic        out_en_b
);
  AST_HOLD_WITHOUT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_exec |=> ($stable(rb_code_a) && $stable(rb_code_b) && $stable(rb_sd_a) && $stable(rb_sd_b))); // R7
  AST_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_exec && cmd_word[8]) |=> (rb_code_a == $past(cmd_word[7:0]))); // R3
  AST_LOAD_B: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_exec && cmd_word[9]) |=> (rb_code_b == $past(cmd_word[7:0]))); // R3
  AST_KEEP_A: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_exec && !cmd_word[8]) |=> $stable(rb_code_a)); // R4
  AST_KEEP_B: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_exec && !cmd_word[9]) |=> $stable(rb_code_b)); // R4
  AST_SHUT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_exec |=> (rb_sd_a == $past(cmd_word[11]) && rb_sd_b == $past(cmd_word[12]))); // R5
  AST_OUT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en_a == !rb_sd_a) && (out_code_a == (rb_sd_a ? 8'h00 : rb_code_a))); // R6
  AST_OUT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en_b == !rb_sd_b) && (out_code_b == (rb_sd_b ? 8'h00 : rb_code_b))); // R6
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_exec(evt_exec), .cmd_word(cmd_word),
  .rb_code_a(rb_code_a), .rb_code_b(rb_code_b),
  .rb_sd_a(rb_sd_a), .rb_sd_b(rb_sd_b),
  .out_code_a(out_code_a), .out_code_b(out_code_b),
  .out_en_a(out_en_a), .out_en_b(out_en_b)
);

// File: tb/dual_dac_ctrl_tb.sv
`timescale 1ns/1ps
module dual_dac_ctrl_tb;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_cs_n = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_din = 1'b0;
  logic [7:0] out_code_a, out_code_b, rb_code_a, rb_code_b;
  logic out_en_a, out_en_b, rb_sd_a, rb_sd_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] m_ca = 8'h00, m_cb = 8'h00;
  logic m_sa = 1'b0, m_sb = 1'b0;

  always #2.5 clk = ~clk;

  dual_dac_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .out_code_a(out_code_a), .out_code_b(out_code_b), .out_en_a(out_en_a), .out_en_b(out_en_b),
    .rb_code_a(rb_code_a), .rb_code_b(rb_code_b), .rb_sd_a(rb_sd_a), .rb_sd_b(rb_sd_b)
  );

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_cmd(logic [15:0] w);
    if (w[8]) m_ca = w[7:0];
    if (w[9]) m_cb = w[7:0];
    m_sa = w[11];
    m_sb = w[12];
  endtask

  task automatic check_state(string req);
    logic [35:0] act, exp;
    act = {out_en_a, out_en_b, rb_sd_a, rb_sd_b, out_code_a, out_code_b, rb_code_a, rb_code_b};
    exp = {~m_sa, ~m_sb, m_sa, m_sb, (m_sa ? 8'h00 : m_ca), (m_sb ? 8'h00 : m_cb), m_ca, m_cb};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_clk = 1'b0;
      ser_din = v[i];
      wait_n(HALF);
      ser_clk = 1'b1;
      wait_n(HALF);
    end
    ser_clk = 1'b0;
    wait_n(HALF);
  endtask

  task automatic sel_low();
    ser_cs_n = 1'b0;
    wait_n(HALF);
  endtask

  task automatic sel_high();
    ser_cs_n = 1'b1;
    wait_n(8);
  endtask

  task automatic frame(logic [15:0] w);
    sel_low();
    send_bits({16'h0, w}, 16);
    sel_high();
    model_cmd(w);
  endtask

  task automatic t_reset();
    check_state("R1 reset state");
  endtask

  task automatic t_loads();
    frame(16'h0380); check_state("R3 load both 80");
    frame(16'h01A5); check_state("R3 R4 load A only");
    frame(16'h025A); check_state("R3 R4 load B only");
    frame(16'h0033); check_state("R4 no load bits");
  endtask

  task automatic t_shutdown();
    frame(16'h0800); check_state("R5 R6 shut A, code kept");
    frame(16'h1BC3); check_state("R5 R6 shut both with load");
    frame(16'h1000); check_state("R5 R6 A active, B shut");
    frame(16'h0000); check_state("R6 both restored");
  endtask

  task automatic t_midframe();
    sel_low();
    send_bits({16'h0, 16'h0311}, 16);
    wait_n(10);
    check_state("R7 no change before select rises");
    sel_high();
    model_cmd(16'h0311);
    check_state("R7 executes after select rises");
  endtask

  task automatic t_bad_count();
    sel_low(); send_bits({17'h0, 15'h0377}, 15); sel_high();
    check_state("R8 15-bit frame ignored");
    sel_low(); send_bits({15'h0, 1'b0, 16'h1B99}, 17); sel_high();
    check_state("R8 17-bit frame ignored");
    sel_low(); sel_high();
    check_state("R8 empty select pulse ignored");
  endtask

  task automatic t_split();
    sel_low();
    send_bits({24'h0, 8'h02}, 8);
    wait_n(60);
    send_bits({24'h0, 8'h6E}, 8);
    sel_high();
    model_cmd(16'h026E);
    check_state("R9 split frame as one command");
  endtask

  task automatic t_uncommitted();
    frame(16'hE73C);
    m_ca = 8'h3C; m_cb = 8'h3C; m_sa = 1'b0; m_sb = 1'b0;
    check_state("R10 uncommitted bits ignored");
  endtask

  task automatic t_clk_while_high();
    ser_din = 1'b1;
    for (int k = 0; k < 5; k++) begin
      ser_clk = 1'b1; wait_n(HALF);
      ser_clk = 1'b0; wait_n(HALF);
    end
    check_state("R11 edges with select high change nothing");
    frame(16'h01C7);
    check_state("R11 R2 next frame counted from zero");
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    t_reset();
    t_loads();
    t_shutdown();
    t_midframe();
    t_bad_count();
    t_split();
    t_uncommitted();
    t_clk_while_high();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule